// File: doc/BRIEF.md
# Interrupt queue and dispatch controller

This unit sits beside a 16-bit processor core and owns its pending interrupt messages. Messages come in on one enqueue port, from attached devices or from a software interrupt instruction. They are held in a circular queue until the core reaches an instruction boundary with delivery allowed. The unit then takes the oldest message and runs a short entry sequence. It stores the core's program counter and then its A register on the stack, which grows downward. It then hands the core three register loads: the program counter from the handler address register, A from the message, and the lowered stack pointer.

A single defer flag holds delivery off while a handler runs. The core drives its interrupt-related instructions as strobes: return from handler, set or clear the defer flag, and write the handler address. The handler address can be read at any time. The return strobe clears the defer flag and reads A and then the program counter back from the stack. While an entry or return sequence runs, `busy` is high and the core must stall. The stack memory is outside the unit. It has a one-cycle synchronous read.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the defer flag, the fault flag, the handler address and `busy` are all 0, and the queue is empty: an instruction boundary right after reset starts no delivery.
- R2: Messages are delivered in the order they were accepted, including after the queue indices wrap past the last slot.
- R3: A delivery takes exactly three busy cycles. Cycle 1 writes the saved program counter at SP-1. Cycle 2 writes the saved A at SP-2. Cycle 3 asserts all three loads with program counter = handler address, A = message and SP = SP-2.
- R4: A delivery starts only in a cycle where `at_boundary` is 1, the unit is idle, no control strobe is active, the defer flag is 0 and the queue is not empty. Starting a delivery sets the defer flag to 1.
- R5: If the handler address is 0 when a message is taken, that message is discarded. There is no stack write and no register load, and the defer flag stays 0.
- R6: A message with `enq_sw`=1 is discarded while the handler address is 0. A message with `enq_sw`=0 is accepted whatever the handler address.
- R7: The queue holds at most DEPTH-1 messages. An enqueue to a full queue is discarded and sets the fault flag, which stays 1 until reset.
- R8: A return strobe clears the defer flag and takes three busy cycles. It reads the stack at SP, then at SP+1, and then loads A with the first word, the program counter with the second word, and SP with SP+2.
- R9: A queue-control strobe sets the defer flag when its operand is non-zero and clears it when the operand is 0.
- R10: A handler write strobe stores its operand, and the `hnd_addr` output shows the stored value.
- R11: No message is ever taken from an empty queue. The head index moves only when the queue held at least one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enq_valid | input | 1 | Enqueue a message this cycle |
| enq_sw | input | 1 | 1 = the message comes from the software interrupt instruction |
| enq_msg | input | W | Message to enqueue |
| at_boundary | input | 1 | The core is between instructions and can take an interrupt |
| ret_req | input | 1 | Return-from-handler strobe |
| qctl_req | input | 1 | Queue-control strobe |
| qctl_val | input | W | Queue-control operand |
| hnd_wr | input | 1 | Handler address write strobe |
| hnd_wdata | input | W | New handler address |
| hnd_addr | output | W | Current handler address |
| core_pc | input | W | Core program counter |
| core_a | input | W | Core A register |
| core_sp | input | W | Core stack pointer |
| stk_we | output | 1 | Stack write |
| stk_re | output | 1 | Stack read; the data arrives in the next cycle |
| stk_addr | output | W | Stack address |
| stk_wdata | output | W | Stack write data |
| stk_rdata | input | W | Stack read data |
| ld_pc | output | 1 | Load the core program counter |
| ld_a | output | 1 | Load the core A register |
| ld_sp | output | 1 | Load the core stack pointer |
| ld_pc_val | output | W | Program counter load value |
| ld_a_val | output | W | A load value |
| ld_sp_val | output | W | Stack pointer load value |
| busy | output | 1 | An entry or return sequence is running; the core stalls |
| deferred | output | 1 | Defer flag |
| q_fault | output | 1 | Sticky queue overflow flag |

## Verification
The assertions assume a well-behaved core. It never raises a return, queue-control or handler-write strobe while `busy` is high. Its stack memory returns read data one cycle after the read strobe. The stimulus keeps to this: each scenario waits for `busy` to fall before it drives the next strobe. The bench's stack model is a synchronous one-cycle memory, and the core registers change only through the three load outputs or through a bench-side preset between sequences. The scenarios cover an entry followed by a return, deferred delivery, a handler address of zero, and a queue filled to capacity and then drained across the index wrap.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int DEPTH = 256,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_valid,
  input  logic         enq_sw,
  input  logic [W-1:0] enq_msg,
  input  logic         at_boundary,
  input  logic         ret_req,
  input  logic         qctl_req,
  input  logic [W-1:0] qctl_val,
  input  logic         hnd_wr,
  input  logic [W-1:0] hnd_wdata,
  output logic [W-1:0] hnd_addr,
  input  logic [W-1:0] core_pc,
  input  logic [W-1:0] core_a,
  input  logic [W-1:0] core_sp,
  output logic         stk_we,
  output logic         stk_re,
  output logic [W-1:0] stk_addr,
  output logic [W-1:0] stk_wdata,
  input  logic [W-1:0] stk_rdata,
  output logic         ld_pc,
  output logic         ld_a,
  output logic         ld_sp,
  output logic [W-1:0] ld_pc_val,
  output logic [W-1:0] ld_a_val,
  output logic [W-1:0] ld_sp_val,
  output logic         busy,
  output logic         deferred,
  output logic         q_fault
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PC, S_PUSH_A, S_ENTER, S_POP_A, S_POP_PC, S_LEAVE
  } st_t;

  st_t           state;
  logic [AW-1:0] head, tail;
  logic [W-1:0]  qmem [DEPTH];
  logic [W-1:0]  msg_r, pc_r, a_r, sp_r, hnd_r;
  logic          defer_r, fault_r;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] idx);
    return (idx == LAST) ? '0 : idx + 1'b1;
  endfunction

  logic q_empty, q_full, src_ok, enq_ok, ctl_any, take, hnd_zero;

  assign hnd_zero = (hnd_r == '0);
  assign q_empty  = (head == tail);
  assign q_full   = (step(tail) == head);
  assign src_ok   = enq_valid && (!enq_sw || !hnd_zero);
  assign enq_ok   = src_ok && !q_full;
  assign ctl_any  = ret_req || qctl_req || hnd_wr;
  assign take     = (state == S_IDLE) && at_boundary && !ctl_any && !defer_r && !q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      for (int i = 0; i < DEPTH; i++) qmem[i] <= '0;
    end else begin
      if (enq_ok) begin
        qmem[tail] <= enq_msg;
        tail       <= step(tail);
      end
      if (take) head <= step(head);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fault_r <= 1'b0;
    else if (src_ok && q_full)     fault_r <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hnd_r <= '0;
    else if (hnd_wr)  hnd_r <= hnd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             defer_r <= 1'b0;
    else if (state == S_IDLE && ret_req)    defer_r <= 1'b0;
    else if (qctl_req)                      defer_r <= (qctl_val != '0);
    else if (take && !hnd_zero)             defer_r <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      msg_r <= '0;
      pc_r  <= '0;
      a_r   <= '0;
      sp_r  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ret_req) begin
            sp_r  <= core_sp;
            state <= S_POP_A;
          end else if (take && !hnd_zero) begin
            msg_r <= qmem[head];
            pc_r  <= core_pc;
            a_r   <= core_a;
            sp_r  <= core_sp;
            state <= S_PUSH_PC;
          end
        end
        S_PUSH_PC: begin
          sp_r  <= sp_r - 1'b1;
          state <= S_PUSH_A;
        end
        S_PUSH_A: begin
          sp_r  <= sp_r - 1'b1;
          state <= S_ENTER;
        end
        S_POP_A: begin
          sp_r  <= sp_r + 1'b1;
          state <= S_POP_PC;
        end
        S_POP_PC: begin
          a_r   <= stk_rdata;
          sp_r  <= sp_r + 1'b1;
          state <= S_LEAVE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic loading;
  assign loading   = (state == S_ENTER) || (state == S_LEAVE);
  assign stk_we    = (state == S_PUSH_PC) || (state == S_PUSH_A);
  assign stk_re    = (state == S_POP_A) || (state == S_POP_PC);
  assign stk_addr  = stk_we ? sp_r - 1'b1 : sp_r;
  assign stk_wdata = (state == S_PUSH_PC) ? pc_r : a_r;
  assign ld_pc     = loading;
  assign ld_a      = loading;
  assign ld_sp     = loading;
  assign ld_pc_val = (state == S_LEAVE) ? stk_rdata : hnd_r;
  assign ld_a_val  = (state == S_LEAVE) ? a_r : msg_r;
  assign ld_sp_val = sp_r;
  assign busy      = (state != S_IDLE);
  assign deferred  = defer_r;
  assign q_fault   = fault_r;
  assign hnd_addr  = hnd_r;

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !deferred && !q_fault); // R1
  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we && !$past(stk_we) |=> stk_we && stk_addr == $past(stk_addr) - 1'b1); // R3
  AST_ENTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we && $past(stk_we) |=> ld_pc && ld_a && ld_sp && ld_sp_val == $past(stk_addr)); // R3
  AST_DEFER_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |-> deferred); // R4
  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    head != $past(head) && $past(hnd_addr) == '0 |-> !busy && !deferred); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q_fault |=> q_fault); // R7
  AST_RET_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && !busy |=> stk_re && !deferred); // R8
  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> !busy); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    head != $past(head) |-> $past(head != tail)); // R11

endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int CLK_T = 10;
  localparam int DEPTH = 256;
  localparam int W     = 16;
  localparam logic [W-1:0] HND = 16'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  logic         enq_valid = 0, enq_sw = 0, at_boundary = 0;
  logic         ret_req = 0, qctl_req = 0, hnd_wr = 0;
  logic [W-1:0] enq_msg = '0, qctl_val = '0, hnd_wdata = '0;
  logic [W-1:0] hnd_addr, stk_addr, stk_wdata, ld_pc_val, ld_a_val, ld_sp_val;
  logic         stk_we, stk_re, ld_pc, ld_a, ld_sp, busy, deferred, q_fault;
  logic [W-1:0] stk_rdata = '0;
  logic [W-1:0] c_pc = '0, c_a = '0, c_sp = '0;
  logic         core_set = 0;
  logic [W-1:0] n_pc = '0, n_a = '0, n_sp = '0;
  logic [W-1:0] smem [256];

  irq_dispatch #(.DEPTH(DEPTH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_sw(enq_sw), .enq_msg(enq_msg),
    .at_boundary(at_boundary), .ret_req(ret_req), .qctl_req(qctl_req), .qctl_val(qctl_val),
    .hnd_wr(hnd_wr), .hnd_wdata(hnd_wdata), .hnd_addr(hnd_addr),
    .core_pc(c_pc), .core_a(c_a), .core_sp(c_sp),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .ld_pc(ld_pc), .ld_a(ld_a), .ld_sp(ld_sp),
    .ld_pc_val(ld_pc_val), .ld_a_val(ld_a_val), .ld_sp_val(ld_sp_val),
    .busy(busy), .deferred(deferred), .q_fault(q_fault));

  always @(posedge clk) begin
    if (stk_we) smem[stk_addr[7:0]] <= stk_wdata;
    if (stk_re) stk_rdata <= smem[stk_addr[7:0]];
    if (ld_pc) c_pc <= ld_pc_val; else if (core_set) c_pc <= n_pc;
    if (ld_a)  c_a  <= ld_a_val;  else if (core_set) c_a  <= n_a;
    if (ld_sp) c_sp <= ld_sp_val; else if (core_set) c_sp <= n_sp;
  end

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_core(input logic [W-1:0] pc, input logic [W-1:0] a, input logic [W-1:0] sp);
    n_pc = pc; n_a = a; n_sp = sp; core_set = 1;
    tick(1);
    core_set = 0;
  endtask

  task automatic enq(input logic [W-1:0] m, input bit sw);
    enq_valid = 1; enq_sw = sw; enq_msg = m;
    tick(1);
    enq_valid = 0; enq_sw = 0;
  endtask

  task automatic set_hnd(input logic [W-1:0] v);
    hnd_wr = 1; hnd_wdata = v;
    tick(1);
    hnd_wr = 0;
  endtask

  task automatic qctl(input logic [W-1:0] v);
    qctl_req = 1; qctl_val = v;
    tick(1);
    qctl_req = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 20) begin n++; tick(1); end
  endtask

  task automatic boundary(output int n);
    at_boundary = 1;
    tick(1);
    at_boundary = 0;
    busy_len(n);
  endtask

  task automatic do_ret(output int n);
    ret_req = 1;
    tick(1);
    ret_req = 0;
    busy_len(n);
  endtask

  task automatic t_reset();
    int n;
    check(!busy && !deferred && !q_fault, "R1 idle flags", {busy, deferred, q_fault}, 0);
    check(hnd_addr == 0, "R1 handler cleared", hnd_addr, 0);
    boundary(n);
    check(n == 0, "R1/R11 empty queue no delivery", W'(n), 0);
  endtask

  task automatic t_handler();
    set_hnd(16'h1357);
    check(hnd_addr == 16'h1357, "R10 handler readback", hnd_addr, 16'h1357);
    set_hnd(HND);
    check(hnd_addr == HND, "R10 handler rewrite", hnd_addr, HND);
  endtask

  task automatic t_entry_return();
    int n;
    set_core(16'h1234, 16'hAAAA, 16'h0080);
    enq(16'h0011, 0);
    enq(16'h0022, 0);
    boundary(n);
    check(n == 3, "R3 entry busy cycles", W'(n), 3);
    check(c_pc == HND, "R3 pc loaded", c_pc, HND);
    check(c_a == 16'h0011, "R3 a loaded", c_a, 16'h0011);
    check(c_sp == 16'h007E, "R3 sp lowered", c_sp, 16'h007E);
    check(smem[8'h7F] == 16'h1234, "R3 pc pushed first", smem[8'h7F], 16'h1234);
    check(smem[8'h7E] == 16'hAAAA, "R3 a pushed second", smem[8'h7E], 16'hAAAA);
    check(deferred, "R4 defer set on entry", W'(deferred), 1);
    boundary(n);
    check(n == 0, "R4 deferred blocks delivery", W'(n), 0);
    do_ret(n);
    check(n == 3, "R8 return busy cycles", W'(n), 3);
    check(c_a == 16'hAAAA, "R8 a restored", c_a, 16'hAAAA);
    check(c_pc == 16'h1234, "R8 pc restored", c_pc, 16'h1234);
    check(c_sp == 16'h0080, "R8 sp restored", c_sp, 16'h0080);
    check(!deferred, "R8 defer cleared", W'(deferred), 0);
    boundary(n);
    check(c_a == 16'h0022, "R2 second message in order", c_a, 16'h0022);
    do_ret(n);
  endtask

  task automatic t_qctl();
    int n;
    qctl(16'h0005);
    check(deferred, "R9 nonzero sets defer", W'(deferred), 1);
    enq(16'h0033, 0);
    boundary(n);
    check(n == 0, "R9 no delivery while deferred", W'(n), 0);
    qctl(16'h0000);
    check(!deferred, "R9 zero clears defer", W'(deferred), 0);
    boundary(n);
    check(n == 3 && c_a == 16'h0033, "R9 delivery after clear", c_a, 16'h0033);
    do_ret(n);
  endtask

  task automatic t_zero_handler();
    int n;
    set_hnd(16'h0000);
    enq(16'h0044, 0);
    boundary(n);
    check(n == 0 && !deferred, "R5 dropped with zero handler", W'(n), 0);
    set_hnd(HND);
    enq(16'h0055, 0);
    boundary(n);
    check(c_a == 16'h0055, "R5 dropped message gone", c_a, 16'h0055);
    do_ret(n);
  endtask

  task automatic t_sw_ignore();
    int n;
    set_hnd(16'h0000);
    enq(16'h0066, 1);
    set_hnd(HND);
    enq(16'h0077, 1);
    boundary(n);
    check(c_a == 16'h0077, "R6 software msg ignored at zero handler", c_a, 16'h0077);
    do_ret(n);
    boundary(n);
    check(n == 0, "R6 queue empty after", W'(n), 0);
  endtask

  task automatic t_overflow();
    int n, miss;
    for (int i = 0; i < DEPTH - 1; i++) enq(W'(16'h0100 + i), 0);
    check(!q_fault, "R7 full queue no fault", W'(q_fault), 0);
    enq(16'hDEAD, 0);
    check(q_fault, "R7 overflow fault", W'(q_fault), 1);
    miss = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      boundary(n);
      if (c_a != W'(16'h0100 + i)) miss++;
      do_ret(n);
    end
    check(miss == 0, "R2/R7 drained in order across wrap", W'(miss), 0);
    boundary(n);
    check(n == 0, "R7/R11 overflowed message discarded", W'(n), 0);
    check(q_fault, "R7 fault sticky", W'(q_fault), 1);
  endtask

  task automatic t_reset_clears();
    int n;
    enq(16'h0088, 0);
    qctl(16'h0001);
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
    check(!q_fault && !deferred, "R1 reset clears fault and defer", {q_fault, deferred}, 0);
    set_hnd(HND);
    boundary(n);
    check(n == 0, "R1 reset empties queue", W'(n), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_handler();
    t_entry_return();
    t_qctl();
    t_zero_handler();
    t_sw_ignore();
    t_overflow();
    t_reset_clears();
    summary();
  end
endmodule